// File: doc/BRIEF.md
# Table-Based Normalized Square Root

This block returns an approximate integer square root of a 32-bit unsigned operand after one clock, without iterating. A coarse classifier counts how many leading 4-bit groups of the operand are zero and picks a 16-bit slice of the operand from that count. The slice is always aligned to an even bit position, so its square root, scaled back up by a power of two, approximates the root of the whole operand. This follows from sqrt(4^k·x) = 2^k·sqrt(x).

The square root of the 16-bit slice is looked up as floor(sqrt(slice)) in 8 bits. That value is shifted left by 2k and zero-filled into a 16-bit result register. Small operands, below 2^16, use the slice made of their low 16 bits, so their result is exact. Larger operands lose at most the fractional part of the slice root, scaled up by the shift.

A producer presents an operand together with a valid strobe. The root appears on the output, with its own valid flag, one clock later. The output register keeps its value in cycles where no operand is presented.

Top module: `nibble_sqrt`

## Requirements
- R1: For an accepted operand below 2^16, the result equals floor(sqrt(operand)) exactly.
- R2: The level k is the smallest value in 0..4 such that operand bits 31 down to 16+4k are all zero. Level 4 is used when bits 31..28 are not all zero. The slice used for the root is operand bits 15+4k down to 4k.
- R3: The 16-bit result equals floor(sqrt(slice)) shifted left by 2k, with zeros filled in from the right.
- R4: valid_o is high in exactly the cycle after a rising clock edge at which valid_i was high. root_o carries that operand's result in the same cycle.
- R5: At a rising edge where valid_i is low, root_o keeps its previous value.
- R6: While rst_ni is low, valid_o and root_o are zero. This takes effect without waiting for a clock edge.
- R7: The result never exceeds floor(sqrt(operand)). For operands of 2^16 and above, the shortfall is less than 2% of floor(sqrt(operand)).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| op_i | input | 32 | Unsigned operand |
| valid_o | output | 1 | Result strobe, one clock after valid_i |
| root_o | output | 16 | Approximate integer square root |

## Verification
The properties assume that valid_i and op_i are known at every rising edge. They also assume that valid_i is low while reset is asserted, so the first cycle after reset refers back to a cycle with no operand. The stimulus keeps these assumptions: it holds valid_i low through every reset and changes inputs only on the falling edge. During idle cycles it drives random operands, so that ignored data is actually present on the inputs. The random operands span every level. Directed values sit on each level boundary and at the bottom of each slice range, where the shortfall is largest.

// File: rtl/nibble_sqrt_pkg.sv
package nibble_sqrt_pkg;
  localparam int unsigned NS_IN_W   = 32;  // operand width
  localparam int unsigned NS_WIN_W  = 16;  // slice (table address) width
  localparam int unsigned NS_STEP_W = 4;   // classifier granularity, must be even
endpackage

// File: rtl/nibble_sqrt_window.sv
module nibble_sqrt_window #(
  parameter int unsigned IN_W    = 32,
  parameter int unsigned WIN_W   = 16,
  parameter int unsigned STEP_W  = 4,
  parameter int unsigned NUM_LVL = (IN_W - WIN_W) / STEP_W + 1,
  parameter int unsigned LVL_W   = $clog2(NUM_LVL)
) (
  input  logic [IN_W-1:0]  src_i,
  output logic [WIN_W-1:0] win_o,
  output logic [LVL_W-1:0] lvl_o
);
  // smallest level whose upper bits are all clear; top level is the fallback
  always_comb begin
    lvl_o = LVL_W'(NUM_LVL - 1);
    for (int k = int'(NUM_LVL) - 2; k >= 0; k--) begin
      if ((src_i >> (WIN_W + STEP_W * k)) == '0) lvl_o = LVL_W'(k);
    end
  end

  assign win_o = WIN_W'(src_i >> (STEP_W * lvl_o));
endmodule

// File: rtl/nibble_sqrt_root.sv
module nibble_sqrt_root #(
  parameter int unsigned WIN_W  = 16,
  parameter int unsigned ROOT_W = WIN_W / 2
) (
  input  logic [WIN_W-1:0]  win_i,
  output logic [ROOT_W-1:0] root_o
);
  localparam int unsigned REM_W = ROOT_W + 3;

  // digit-by-digit restoring root, one stage per result bit
  logic [REM_W-1:0]  rem_s  [ROOT_W];
  logic [ROOT_W-1:0] root_s [ROOT_W+1];

  assign rem_s[0]  = '0;
  assign root_s[0] = '0;

  for (genvar j = 0; j < ROOT_W; j++) begin : g_stage
    localparam int unsigned PAIR = ROOT_W - 1 - j;
    logic [REM_W-1:0] part;
    logic [REM_W-1:0] trial;
    logic             take;

    assign part  = (rem_s[j] << 2) | REM_W'(win_i[2*PAIR +: 2]);
    assign trial = (REM_W'(root_s[j]) << 2) | REM_W'(1);
    assign take  = part >= trial;
    assign root_s[j+1] = (root_s[j] << 1) | ROOT_W'(take);

    if (j < ROOT_W - 1) begin : g_rem
      assign rem_s[j+1] = take ? part - trial : part;
    end
  end

  assign root_o = root_s[ROOT_W];
endmodule

// File: rtl/nibble_sqrt.sv
module nibble_sqrt
  import nibble_sqrt_pkg::*;
#(
  parameter  int unsigned IN_W    = NS_IN_W,
  parameter  int unsigned WIN_W   = NS_WIN_W,
  parameter  int unsigned STEP_W  = NS_STEP_W,
  localparam int unsigned NUM_LVL = (IN_W - WIN_W) / STEP_W + 1,
  localparam int unsigned ROOT_W  = WIN_W / 2,
  localparam int unsigned OUT_W   = ROOT_W + (NUM_LVL - 1) * (STEP_W / 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  op_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] root_o
);
  localparam int unsigned LVL_W = $clog2(NUM_LVL);

  logic [WIN_W-1:0]  win;
  logic [LVL_W-1:0]  lvl;
  logic [ROOT_W-1:0] tbl_root;
  logic [OUT_W-1:0]  root_d;

  nibble_sqrt_window #(
    .IN_W   (IN_W),
    .WIN_W  (WIN_W),
    .STEP_W (STEP_W),
    .NUM_LVL(NUM_LVL),
    .LVL_W  (LVL_W)
  ) i_window (
    .src_i(op_i),
    .win_o(win),
    .lvl_o(lvl)
  );

  nibble_sqrt_root #(
    .WIN_W (WIN_W),
    .ROOT_W(ROOT_W)
  ) i_root (
    .win_i (win),
    .root_o(tbl_root)
  );

  // undo the 4^k scaling of the slice: each level is worth STEP_W/2 bits of root
  assign root_d = OUT_W'(tbl_root) << (lvl * (STEP_W / 2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      root_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) root_o <= root_d;
    end
  end
endmodule

// File: rtl/nibble_sqrt_chk.sv
module nibble_sqrt_chk #(
  parameter int unsigned IN_W  = 32,
  parameter int unsigned OUT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [IN_W-1:0]  op_i,
  input logic             valid_o,
  input logic [OUT_W-1:0] root_o
);
  logic [63:0] sq_lo, sq_hi;
  assign sq_lo = 64'(root_o) * 64'(root_o);
  assign sq_hi = (64'(root_o) + 64'd1) * (64'(root_o) + 64'd1);

  assert_valid_lat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> $stable(root_o));

  assert_reset_clear_R6: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && root_o == '0));

  assert_small_exact_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && (64'($past(op_i)) < 64'h1_0000)) |->
      (sq_lo <= 64'($past(op_i)) && sq_hi > 64'($past(op_i))));

  assert_no_overshoot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i) |-> (sq_lo <= 64'($past(op_i))));
endmodule

bind nibble_sqrt nibble_sqrt_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) i_nibble_sqrt_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .op_i   (op_i),
  .valid_o(valid_o),
  .root_o (root_o)
);

// File: tb/test_nibble_sqrt.sv
`timescale 1ns/1ps
module test_nibble_sqrt;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] op_i = '0;
  logic        valid_o;
  logic [15:0] root_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  nibble_sqrt i_nibble_sqrt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .op_i   (op_i),
    .valid_o(valid_o),
    .root_o (root_o)
  );

  // exact floor root by bit-wise search on squares
  function automatic logic [31:0] ref_isqrt(input logic [31:0] x);
    logic [31:0] r = '0;
    for (int b = 15; b >= 0; b--) begin
      logic [31:0] t = r | (32'd1 << b);
      if (64'(t) * 64'(t) <= 64'(x)) r = t;
    end
    return r;
  endfunction

  // R2/R3 rule written out level by level
  function automatic logic [31:0] ref_root(input logic [31:0] x);
    int k;
    if (x[31:16] == 0)      k = 0;
    else if (x[31:20] == 0) k = 1;
    else if (x[31:24] == 0) k = 2;
    else if (x[31:28] == 0) k = 3;
    else                    k = 4;
    return (ref_isqrt((x >> (4 * k)) & 32'hFFFF) << (2 * k)) & 32'hFFFF;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic check_result(input logic [31:0] x);
    logic [31:0] f = ref_isqrt(x);
    chk(valid_o === 1'b1, "R4 valid", 32'(valid_o), 32'd1);
    chk(32'(root_o) === ref_root(x), "R2/R3 window rule", 32'(root_o), ref_root(x));
    if (x < 32'h1_0000) begin
      chk(32'(root_o) === f, "R1 exact small", 32'(root_o), f);
    end else begin
      chk(32'(root_o) <= f && 64'd100 * 64'(f - 32'(root_o)) < 64'd2 * 64'(f),
          "R7 bound", 32'(root_o), f);
    end
  endtask

  task automatic run_one(input logic [31:0] x);
    logic [15:0] held;
    @(negedge clk_i);
    valid_i = 1'b1;
    op_i = x;
    @(negedge clk_i);
    valid_i = 1'b0;
    op_i = $urandom;
    check_result(x);
    held = root_o;
    @(negedge clk_i);
    chk(valid_o === 1'b0, "R4 idle", 32'(valid_o), 32'd0);
    chk(root_o === held, "R5 hold", 32'(root_o), 32'(held));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] prev;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    chk(valid_o === 1'b0, "R6 reset valid", 32'(valid_o), 32'd0);
    chk(root_o === 16'd0, "R6 reset root", 32'(root_o), 32'd0);
    rst_ni = 1'b1;

    // directed: boundaries of each level and low edge of each slice
    run_one(32'd0);
    run_one(32'd1);
    run_one(32'd2);
    run_one(32'd3);
    run_one(32'd4);
    run_one(32'd15);
    run_one(32'd16);
    run_one(32'h0000_FFFF);
    run_one(32'h0001_0000);
    run_one(32'h0001_0FFF);
    run_one(32'h000F_FFFF);
    run_one(32'h0010_0000);
    run_one(32'h0010_FFFF);
    run_one(32'h00FF_FFFF);
    run_one(32'h0100_0000);
    run_one(32'h0FFF_FFFF);
    run_one(32'h1000_0000);
    run_one(32'hFFFF_FFFF);

    // random over full range and over varied magnitudes
    for (int n = 0; n < 300; n++) run_one($urandom);
    for (int n = 0; n < 400; n++) run_one($urandom >> ($urandom % 32));

    // back-to-back stream: R4 one result per cycle
    @(negedge clk_i);
    prev = $urandom >> ($urandom % 32);
    valid_i = 1'b1;
    op_i = prev;
    for (int n = 0; n < 200; n++) begin
      logic [31:0] nx = $urandom >> ($urandom % 32);
      @(negedge clk_i);
      check_result(prev);
      op_i = nx;
      prev = nx;
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    check_result(prev);

    // asynchronous reset mid-run: R6
    run_one(32'hFFFF_FFFF);
    #1 rst_ni = 1'b0;
    #1;
    chk(valid_o === 1'b0, "R6 async valid", 32'(valid_o), 32'd0);
    chk(root_o === 16'd0, "R6 async root", 32'(root_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_one(32'd4);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule